// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

The block is a clock-master serial audio sender. It divides the system clock into a bit clock and drives a word-select line and one serial data line. Samples arrive on a valid/ready input, one sample per accepted transfer. The sample's bits sit in its low-order positions. Each frame is a run of fixed-width slots of `SLOT_BITS` bit clocks each.

In two-channel (dual-phase) mode a frame holds two slots, and word-select marks which channel is on the line. In multi-slot (single-phase, DSP/TDM-style) mode a frame holds `MAX_SLOTS` slots, and word-select is a one-bit-clock marker at the start of the frame.

Static configuration inputs set the following:
- the word length;
- the number of idle bit clocks placed before the word;
- the word-select polarity (tie it high for the standard two-channel format);
- the bit order (tie it low for MSB-first);
- a per-slot channel mask.

The mask decides which slots carry audio and which slots consume input samples. In two-channel mono modes one sample is repeated on the other channel. Once `run` rises, the clocks start at once. Audio begins only after a fixed number of warm-up frames.

Top module: `serial_audio_tx`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `bclk`, `ws`, `sd`, `s_ready` and `underflow` are all low.
- R2: While `run` is high, `bclk` has a period of 2*`CLK_DIV` clock cycles. `sd` and `ws` change only on the `bclk` edge opposite the receiver's sampling edge. The receiver samples on rising edges in two-channel mode and on falling edges in multi-slot mode. While `run` is low, `sd` is low.
- R3: In every slot, bit positions 0 to `cfg_pad_before`-1 are low. The next `cfg_word_len` positions carry sample bits [`cfg_word_len`-1:0]. These go MSB first when `cfg_lsb_first`=0 and LSB first when it is 1. All remaining positions of the slot are low.
- R4: In two-channel mode a frame is slot 0 (channel 1) followed by slot 1 (channel 2). The `ws` line equals 1 XOR `cfg_ws_invert` for every bit of slot 0 and `cfg_ws_invert` for every bit of slot 1.
- R5: In two-channel mode with mask bits [1:0]=11, each slot consumes its own sample, channel 1 first.
- R6: In two-channel mode with mask [1:0]=01, slot 0 consumes a sample and slot 1 repeats that same sample.
- R7: In two-channel mode with mask [1:0]=10, slot 1 consumes a sample and slot 0 of the following frame repeats it. Slot 0 of the first audio frame carries zero.
- R8: In two-channel mode with mask [1:0]=00, every slot is all zeros and no sample is accepted.
- R9: In multi-slot mode a frame has `MAX_SLOTS` slots. Mask bit n enables slot n. Each enabled slot consumes one sample in slot order, and disabled slots are all zeros. `ws` equals 1 XOR `cfg_ws_invert` only at bit 0 of slot 0; at every other bit it equals `cfg_ws_invert`.
- R10: After `run` rises, the first `STARTUP_FRAMES` frames carry all-zero data and accept no samples, while `bclk` and `ws` already run.
- R11: If `s_valid` is low when a sample-consuming slot starts, that slot carries zero and `underflow` sets. It then stays set until `underflow_clr` is pulsed. It never sets while samples are always available.
- R12: `s_ready` is a single-cycle pulse at the start of each sample-consuming slot. Exactly one sample is accepted per such slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Starts clocks and framing; low returns to idle |
| cfg_single_phase | input | 1 | 1 selects multi-slot mode, 0 selects two-channel mode |
| cfg_chan_mask | input | MAX_SLOTS | Per-slot enable; bit n enables slot n |
| cfg_word_len | input | $clog2(MAX_WORD+1) | Bits per sample, 8 to MAX_WORD |
| cfg_pad_before | input | $clog2(SLOT_BITS) | Idle bit clocks before the word in each slot |
| cfg_ws_invert | input | 1 | Inverts the word-select line |
| cfg_lsb_first | input | 1 | 1 sends LSB first |
| s_valid | input | 1 | Sample available |
| s_data | input | MAX_WORD | Sample, right-aligned |
| s_ready | output | 1 | Sample accepted this cycle |
| underflow_clr | input | 1 | Clears the underflow flag |
| underflow | output | 1 | Sticky missing-sample flag |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select / frame marker |
| sd | output | 1 | Serial data |

## Verification
The bench decodes every slot at the receiver's sampling edge and compares it with a model of the mask, mono-repeat and warm-up rules. A slip of the bit or slot counter therefore shows up within the same slot as a shifted word or a misplaced `ws` level. A stale or wrongly captured held word shows up one slot later, in a mono repeat. A wrong consume decision shifts every later slot's sample and changes the accepted-sample count checked at the end of each run. A wrong warm-up counter shows up as audio in the first frames, or as samples missing from them.

// File: rtl/sat_pkg.sv
package sat_pkg;

  // Value of one bit position inside a slot, given the slot's word.
  function automatic logic slot_bit(input logic [31:0] w, input int len,
                                    input int pad, input logic lsb, input int pos);
    int off;
    int idx;
    off = pos - pad;
    if (off < 0 || off >= len) return 1'b0;
    idx = lsb ? off : (len - 1 - off);
    return w[idx[4:0]];
  endfunction

endpackage

// File: rtl/sat_bitclk_gen.sv
module sat_bitclk_gen #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic idle_high,
  output logic bclk,
  output logic launch
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic tick;
  logic bclk_q;

  generate
    if (CLK_DIV == 1) begin : g_nodiv
      assign tick = run;
    end else begin : g_div
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst || !run || div_q == DIV_W'(CLK_DIV - 1)) div_q <= '0;
        else div_q <= div_q + 1'b1;
      end
      assign tick = run && (div_q == DIV_W'(CLK_DIV - 1));
    end
  endgenerate

  // The first toggle away from the idle level is always a launch edge.
  assign launch = tick && (bclk_q == idle_high);
  assign bclk   = bclk_q;

  always_ff @(posedge clk) begin
    if (rst)       bclk_q <= 1'b0;
    else if (!run) bclk_q <= idle_high;
    else if (tick) bclk_q <= ~bclk_q;
  end
endmodule

// File: rtl/sat_slot_seq.sv
module sat_slot_seq #(
  parameter int SLOT_BITS      = 32,
  parameter int MAX_SLOTS      = 8,
  parameter int STARTUP_FRAMES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          run,
  input  logic                          single,
  input  logic                          launch,
  output logic [$clog2(MAX_SLOTS)-1:0]  slot_idx,
  output logic [$clog2(SLOT_BITS)-1:0]  bit_idx,
  output logic                          in_startup
);
  localparam int SLOT_W = $clog2(MAX_SLOTS);
  localparam int BIT_W  = $clog2(SLOT_BITS);
  localparam int SU_W   = $clog2(STARTUP_FRAMES + 2);

  logic [SLOT_W-1:0] slot_q;
  logic [BIT_W-1:0]  bit_q;
  logic [SU_W-1:0]   su_q;
  logic [SLOT_W-1:0] last_slot;

  assign last_slot  = single ? SLOT_W'(MAX_SLOTS - 1) : SLOT_W'(1);
  assign slot_idx   = slot_q;
  assign bit_idx    = bit_q;
  assign in_startup = (su_q < SU_W'(STARTUP_FRAMES));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      slot_q <= '0;
      bit_q  <= '0;
      su_q   <= '0;
    end else if (launch) begin
      if (bit_q == BIT_W'(SLOT_BITS - 1)) begin
        bit_q <= '0;
        if (slot_q == last_slot) begin
          slot_q <= '0;
          if (in_startup) su_q <= su_q + 1'b1;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_word_pick.sv
module sat_word_pick #(
  parameter int MAX_SLOTS = 8,
  parameter int MAX_WORD  = 24,
  parameter int SLOT_W    = 3,
  parameter int BIT_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 launch,
  input  logic                 in_startup,
  input  logic                 single,
  input  logic [MAX_SLOTS-1:0] mask,
  input  logic [SLOT_W-1:0]    slot_idx,
  input  logic [BIT_W-1:0]     bit_idx,
  input  logic                 s_valid,
  input  logic [MAX_WORD-1:0]  s_data,
  output logic                 s_ready,
  input  logic                 uf_clr,
  output logic                 underflow,
  output logic [MAX_WORD-1:0]  cur_word,
  output logic                 slot_active
);
  logic [MAX_WORD-1:0] word_q;
  logic [MAX_WORD-1:0] new_word;
  logic                uf_q;
  logic                slot_en;
  logic                consume;
  logic                slot_start;

  // Two-channel: any of bits 1:0 enables both slots; the slot's own bit decides
  // whether it takes a fresh sample or repeats the held one.
  always_comb begin
    if (single) begin
      slot_en = mask[slot_idx];
      consume = mask[slot_idx];
    end else begin
      slot_en = |mask[1:0];
      consume = mask[slot_idx[0]];
    end
  end

  assign slot_start  = launch && (bit_idx == '0) && !in_startup;
  assign s_ready     = slot_start && consume;
  assign new_word    = consume ? (s_valid ? s_data : '0) : word_q;
  assign cur_word    = (bit_idx == '0) ? new_word : word_q;
  assign slot_active = slot_en && !in_startup;
  assign underflow   = uf_q;

  always_ff @(posedge clk) begin
    if (rst || !run) word_q <= '0;
    else if (s_ready) word_q <= new_word;
  end

  // A new miss wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) uf_q <= 1'b0;
    else if (s_ready && !s_valid) uf_q <= 1'b1;
    else if (uf_clr) uf_q <= 1'b0;
  end
endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx #(
  parameter int CLK_DIV        = 2,
  parameter int SLOT_BITS      = 32,
  parameter int MAX_SLOTS      = 8,
  parameter int MAX_WORD       = 24,
  parameter int STARTUP_FRAMES = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            run,
  input  logic                            cfg_single_phase,
  input  logic [MAX_SLOTS-1:0]            cfg_chan_mask,
  input  logic [$clog2(MAX_WORD+1)-1:0]   cfg_word_len,
  input  logic [$clog2(SLOT_BITS)-1:0]    cfg_pad_before,
  input  logic                            cfg_ws_invert,
  input  logic                            cfg_lsb_first,
  input  logic                            s_valid,
  input  logic [MAX_WORD-1:0]             s_data,
  output logic                            s_ready,
  input  logic                            underflow_clr,
  output logic                            underflow,
  output logic                            bclk,
  output logic                            ws,
  output logic                            sd
);
  localparam int SLOT_W = $clog2(MAX_SLOTS);
  localparam int BIT_W  = $clog2(SLOT_BITS);

  logic              launch;
  logic [SLOT_W-1:0] slot_idx;
  logic [BIT_W-1:0]  bit_idx;
  logic              in_startup;
  logic [MAX_WORD-1:0] cur_word;
  logic              slot_active;
  logic              bit_val;
  logic              ws_int;
  logic              sd_q;
  logic              ws_q;

  sat_bitclk_gen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk(clk), .rst(rst), .run(run), .idle_high(!cfg_single_phase),
    .bclk(bclk), .launch(launch)
  );

  sat_slot_seq #(
    .SLOT_BITS(SLOT_BITS), .MAX_SLOTS(MAX_SLOTS), .STARTUP_FRAMES(STARTUP_FRAMES)
  ) u_seq (
    .clk(clk), .rst(rst), .run(run), .single(cfg_single_phase), .launch(launch),
    .slot_idx(slot_idx), .bit_idx(bit_idx), .in_startup(in_startup)
  );

  sat_word_pick #(
    .MAX_SLOTS(MAX_SLOTS), .MAX_WORD(MAX_WORD), .SLOT_W(SLOT_W), .BIT_W(BIT_W)
  ) u_pick (
    .clk(clk), .rst(rst), .run(run), .launch(launch), .in_startup(in_startup),
    .single(cfg_single_phase), .mask(cfg_chan_mask), .slot_idx(slot_idx),
    .bit_idx(bit_idx), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .uf_clr(underflow_clr), .underflow(underflow), .cur_word(cur_word),
    .slot_active(slot_active)
  );

  assign bit_val = slot_active &&
                   sat_pkg::slot_bit(32'(cur_word), int'(cfg_word_len), int'(cfg_pad_before),
                                     cfg_lsb_first, int'(bit_idx));
  assign ws_int  = cfg_single_phase ? (slot_idx == '0 && bit_idx == '0) : (slot_idx == '0);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sd_q <= 1'b0;
      ws_q <= 1'b0;
    end else if (launch) begin
      sd_q <= bit_val;
      ws_q <= ws_int ^ cfg_ws_invert;
    end
  end

  assign sd = sd_q;
  assign ws = ws_q;
endmodule

// File: rtl/serial_audio_tx_chk.sv
module serial_audio_tx_chk (
  input logic clk,
  input logic rst,
  input logic run,
  input logic s_valid,
  input logic s_ready,
  input logic underflow,
  input logic underflow_clr,
  input logic bclk,
  input logic ws,
  input logic sd
);
  p_ready_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    s_ready |=> !s_ready);

  p_uf_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (underflow && !underflow_clr) |=> underflow);

  p_uf_cause_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(underflow) |-> $past(s_ready && !s_valid));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sd);

  p_sd_on_edge_r2: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$stable(sd)) |-> !$stable(bclk));

  p_ws_on_edge_r4: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$stable(ws)) |-> !$stable(bclk));
endmodule

bind serial_audio_tx serial_audio_tx_chk u_chk (
  .clk(clk), .rst(rst), .run(run), .s_valid(s_valid), .s_ready(s_ready),
  .underflow(underflow), .underflow_clr(underflow_clr), .bclk(bclk), .ws(ws), .sd(sd)
);

// File: tb/serial_audio_tx_bench.sv
module serial_audio_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 2;
  localparam int SLOT_BITS  = 32;
  localparam int MAX_SLOTS  = 8;
  localparam int MAX_WORD   = 24;
  localparam int STARTUP    = 2;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst, run, cfg_single_phase, cfg_ws_invert, cfg_lsb_first;
  logic [MAX_SLOTS-1:0] cfg_chan_mask;
  logic [4:0] cfg_word_len;
  logic [4:0] cfg_pad_before;
  logic s_valid, s_ready, underflow_clr, underflow, bclk, ws, sd;
  logic [MAX_WORD-1:0] s_data;

  serial_audio_tx #(
    .CLK_DIV(CLK_DIV), .SLOT_BITS(SLOT_BITS), .MAX_SLOTS(MAX_SLOTS),
    .MAX_WORD(MAX_WORD), .STARTUP_FRAMES(STARTUP)
  ) u_serial_audio_tx (
    .clk(clk), .rst(rst), .run(run), .cfg_single_phase(cfg_single_phase),
    .cfg_chan_mask(cfg_chan_mask), .cfg_word_len(cfg_word_len),
    .cfg_pad_before(cfg_pad_before), .cfg_ws_invert(cfg_ws_invert),
    .cfg_lsb_first(cfg_lsb_first), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .underflow_clr(underflow_clr), .underflow(underflow),
    .bclk(bclk), .ws(ws), .sd(sd)
  );

  typedef struct {
    logic [SLOT_BITS-1:0] d;
    logic [SLOT_BITS-1:0] w;
    string tag;
    string wtag;
  } exp_t;

  exp_t exp_q[$];
  logic [MAX_WORD-1:0] src_q[$];
  logic [MAX_WORD-1:0] mq[$];
  int n_checks = 0;
  int n_err = 0;
  int pops = 0;
  bit pend = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Sample source: one sample is removed after each accepted handshake.
  initial begin
    s_valid = 1'b0;
    s_data  = '0;
    forever begin
      @(negedge clk);
      if (pend) begin
        void'(src_q.pop_front());
        pops++;
        pend = 0;
      end
      s_valid = (src_q.size() > 0);
      s_data  = s_valid ? src_q[0] : '0;
      if (s_valid && s_ready) pend = 1;
    end
  end

  // Monitor: deserialise each slot at the receiver's sampling edge and score it.
  initial begin
    logic prev_b;
    logic [SLOT_BITS-1:0] vec;
    logic [SLOT_BITS-1:0] wv;
    int cnt;
    int cyc;
    int last_cyc;
    int per_bad;
    int bpos;
    exp_t e;
    prev_b = 1'b0; vec = '0; wv = '0; cnt = 0; cyc = 0; last_cyc = 0; per_bad = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst || !run) begin
        prev_b = bclk;
        cnt = 0;
        per_bad = 0;
      end else begin
        if (bclk !== prev_b && bclk == !cfg_single_phase) begin
          if (cnt > 0 && (cyc - last_cyc) != 2*CLK_DIV) per_bad++;
          last_cyc = cyc;
          bpos = cnt % SLOT_BITS;
          vec[bpos] = sd;
          wv[bpos]  = ws;
          cnt++;
          if (bpos == SLOT_BITS-1 && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk(vec == e.d, e.tag, "slot data", 64'(vec), 64'(e.d));
            chk(wv == e.w, e.wtag, "ws pattern", 64'(wv), 64'(e.w));
            chk(per_bad == 0, "R2", "bclk period faults", 64'(per_bad), 64'(0));
            per_bad = 0;
          end
        end
        prev_b = bclk;
      end
    end
  end

  task automatic build_exp(input bit single, input logic [7:0] mask, input int wlen,
                           input int pad, input bit lsb, input bit inv,
                           input int nframes, input string tag);
    int nsl;
    logic [MAX_WORD-1:0] lw;
    logic [MAX_WORD-1:0] w;
    bit en;
    bit take;
    exp_t e;
    nsl = single ? MAX_SLOTS : 2;
    lw = '0;
    for (int f = 0; f < STARTUP + nframes; f++) begin
      for (int s = 0; s < nsl; s++) begin
        if (single) begin en = mask[s]; take = mask[s]; end
        else begin en = (mask[1:0] != 2'b00); take = mask[s]; end
        if (f < STARTUP) begin en = 0; take = 0; end
        w = lw;
        if (take) begin
          w = (mq.size() > 0) ? mq.pop_front() : '0;
          lw = w;
        end
        e.d = '0;
        e.w = '0;
        for (int b = 0; b < SLOT_BITS; b++) begin
          if (en && b >= pad && b < pad + wlen)
            e.d[b] = lsb ? w[b - pad] : w[wlen - 1 - (b - pad)];
          e.w[b] = single ? (((s == 0) && (b == 0)) ^ inv) : ((s == 0) ^ inv);
        end
        e.tag  = (f < STARTUP) ? "R10" : tag;
        e.wtag = single ? "R9" : "R4";
        exp_q.push_back(e);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; run = 1'b0; underflow_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_case(input bit single, input logic [7:0] mask, input int wlen,
                          input int pad, input bit lsb, input bit inv, input int nframes,
                          input int nsamp, input int seed, input string tag);
    logic [MAX_WORD-1:0] v;
    src_q.delete();
    mq.delete();
    for (int i = 0; i < nsamp; i++) begin
      v = MAX_WORD'(32'h9E3779B1 * (i + seed) + 32'h5A5A17);
      src_q.push_back(v);
      mq.push_back(v);
    end
    cfg_single_phase = single; cfg_chan_mask = mask;
    cfg_word_len = 5'(wlen); cfg_pad_before = 5'(pad);
    cfg_lsb_first = lsb; cfg_ws_invert = inv;
    pops = 0;
    build_exp(single, mask, wlen, pad, lsb, inv, nframes, tag);
    @(negedge clk);
    run = 1'b1;
    wait (exp_q.size() == 0);
    run = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    run = 1'b0; rst = 1'b1; underflow_clr = 1'b0;
    cfg_single_phase = 1'b0; cfg_chan_mask = 8'h03; cfg_word_len = 5'd16;
    cfg_pad_before = 5'd1; cfg_ws_invert = 1'b1; cfg_lsb_first = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({bclk, ws, sd, s_ready, underflow} == 5'b0, "R1", "outputs in reset",
        64'({bclk, ws, sd, s_ready, underflow}), 64'(0));
    do_reset();

    // R5 + R3: stereo, MSB first, one-bit pad, inverted ws
    run_case(1'b0, 8'h03, 16, 1, 1'b0, 1'b1, 3, 10, 1, "R5");
    chk(pops == 6, "R12", "samples accepted stereo", 64'(pops), 64'(6));
    chk(underflow == 1'b0, "R11", "no false underflow", 64'(underflow), 64'(0));
    do_reset();

    // R6: mono, LSB first, full 24-bit word
    run_case(1'b0, 8'h01, 24, 0, 1'b1, 1'b0, 3, 8, 20, "R6");
    chk(pops == 3, "R6", "samples accepted mono", 64'(pops), 64'(3));
    do_reset();

    // R7: inverted mono, 8-bit word, pad 3
    run_case(1'b0, 8'h02, 8, 3, 1'b0, 1'b0, 3, 8, 40, "R7");
    chk(pops == 3, "R7", "samples accepted inv mono", 64'(pops), 64'(3));
    do_reset();

    // R8: no channels; upper mask bits ignored in two-channel mode
    run_case(1'b0, 8'hF0, 16, 0, 1'b0, 1'b1, 2, 4, 60, "R8");
    chk(pops == 0, "R8", "samples accepted none", 64'(pops), 64'(0));
    chk(src_q.size() == 4, "R8", "source untouched", 64'(src_q.size()), 64'(4));
    do_reset();

    // R9: multi-slot, sparse mask
    run_case(1'b1, 8'hA5, 20, 2, 1'b0, 1'b0, 3, 16, 80, "R9");
    chk(pops == 12, "R12", "samples accepted multi-slot", 64'(pops), 64'(12));
    do_reset();

    // R3: multi-slot, all slots, LSB first, word ends at last slot bit
    run_case(1'b1, 8'hFF, 24, 8, 1'b1, 1'b1, 2, 20, 100, "R3");
    chk(pops == 16, "R12", "samples accepted full mask", 64'(pops), 64'(16));
    do_reset();

    // R11: no samples at all
    run_case(1'b0, 8'h03, 16, 0, 1'b0, 1'b1, 2, 0, 0, "R11");
    chk(underflow == 1'b1, "R11", "underflow set", 64'(underflow), 64'(1));
    repeat (10) @(negedge clk);
    chk(underflow == 1'b1, "R11", "underflow sticky", 64'(underflow), 64'(1));
    underflow_clr = 1'b1;
    @(negedge clk);
    underflow_clr = 1'b0;
    @(negedge clk);
    chk(underflow == 1'b0, "R11", "underflow cleared", 64'(underflow), 64'(0));

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 64'(0), 64'(1));
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule